// File: doc/BRIEF.md
# Coprocessor Command Decoder and Run Controller

This block sits between a processor's custom-instruction port and a convolution engine. Each command carries a function code, a source operand and a destination register index, and arrives over a valid/ready handshake. Three commands load the input, kernel and output base addresses. One command launches a run without blocking. One command returns a four-bit status word that software polls until the run ends. Every accepted command gets exactly one response, one cycle later, tagged with the command's destination index.

A four-state controller (idle, busy, done, error) decides which commands the block takes in each state. Before a run starts, the block checks that no base address is zero and that each base meets its alignment rule. The input and output bases use one rule and the kernel base uses another. The compute engine is modelled as a countdown. Its length comes from the start command's operand, and it ends the busy phase by moving the controller to done.

Top module: `cop_cmd_ctrl`

## Requirements
- R1: A command is accepted on a rising edge where `cmdValid` and `cmdReady` are both high. Exactly one cycle later, `rspValid` is high for one cycle and `rspDest` equals the accepted command's destination index. `rspValid` stays low in every other cycle.
- R2: The status word has bit 0 = busy, bit 1 = done, bit 2 = overflow (always 0 in this block) and bit 3 = address error. Function code 4 (poll) is accepted in every state. Its response data is the status word, zero-extended and taken from the cycle in which the poll is accepted.
- R3: Function codes 0, 1 and 2 write the operand into the input, kernel and output base address respectively. Their response data is zero.
- R4: While busy, `cmdReady` is low for codes 0 to 2, and none of the stored base addresses changes.
- R5: Function code 3 (start) is accepted only in idle or done. In busy and in error, `cmdReady` is low for code 3.
- R6: An accepted start moves the block to error, with status 4'b1000, when any of the three stored base addresses is zero.
- R7: An accepted start moves the block to error when the input or output base has any of its low 3 bits set, or when the kernel base has bit 0 set. A kernel base that is only 2-byte aligned is valid.
- R8: An accepted start with valid addresses enters busy, with status 4'b0001. The low `CNT_W` bits of its operand give N. Busy then lasts N+1 cycles, and after that the block is in done, with status 4'b0010.
- R9: Done holds until a command changes it. A set command in done returns the block to idle. A start command in done re-enters busy.
- R10: In error, only a set command leaves the state, and it goes to idle. The block never moves from error straight to busy.
- R11: Function codes above 4 are accepted and answered with data zero. They do not change the state, the countdown or any base address.
- R12: After reset, the block is idle, the status word is zero and `rspValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block takes the presented command this cycle |
| cmdFunc | input | FUNC_W | Function code |
| cmdOperand | input | XLEN | Source operand (address, or run length for start) |
| cmdDest | input | DEST_W | Destination register index |
| rspValid | output | 1 | Response present (one cycle) |
| rspDest | output | DEST_W | Destination index of the answered command |
| rspData | output | XLEN | Zero for set, start and unknown codes; status word for poll |

## Verification
The assertions assume that `cmdFunc`, `cmdOperand` and `cmdDest` are stable while `cmdValid` is high. They also assume that the response port is always able to take a response, because the response path has no backpressure. The stimulus changes command fields only at falling edges and drops `cmdValid` right after each command is accepted or refused. It never withholds a response. The address sweeps cover every low-bit pattern of each base in turn, while the other two bases are held valid. The countdown sweep measures busy length exactly, by polling on back-to-back cycles.

// File: rtl/cop_pkg.sv
package cop_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BUSY = 2'd1,
    ST_DONE = 2'd2,
    ST_ERR  = 2'd3
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [2:0] wrBase;   // one bit per base address slot
    logic       loadCnt;  // load countdown from operand
    logic       tick;     // controller is busy: count down
  } ctlStrobe_t;

  localparam int NUM_BASE   = 3;
  localparam int FN_START   = 3;
  localparam int FN_POLL    = 4;
  localparam int STAT_W     = 4;
  localparam int ST_BIT_BSY = 0;
  localparam int ST_BIT_DON = 1;
  localparam int ST_BIT_OVF = 2;
  localparam int ST_BIT_ERR = 3;

  // alignment bits required per base: input, kernel, output
  function automatic int alignBits(input int idx);
    return (idx == 1) ? 1 : 3;
  endfunction

endpackage

// File: rtl/cop_datapath.sv
module cop_datapath
  import cop_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [XLEN-1:0]  operand,
  output logic             addrOk,
  output logic             cntZero
);

  logic [NUM_BASE-1:0][XLEN-1:0] baseQ;
  logic [NUM_BASE-1:0]           baseOk;
  logic [CNT_W-1:0]              cntQ;

  for (genvar gi = 0; gi < NUM_BASE; gi++) begin : g_base
    localparam int AB = alignBits(gi);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ[gi] <= '0;
      end else if (strobe.wrBase[gi]) begin
        baseQ[gi] <= operand;
      end
    end

    always_comb begin
      baseOk[gi] = (|baseQ[gi]) && (baseQ[gi][AB-1:0] == '0);
    end
  end

  assign addrOk = &baseOk;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.loadCnt) begin
      cntQ <= operand[CNT_W-1:0];
    end else if (strobe.tick && (cntQ != '0)) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  assign cntZero = (cntQ == '0);

  // R4: no base address moves while the controller is busy
  a_r4_base_hold_busy: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tick |=> $stable(baseQ));

  // R8: countdown never reloads while busy
  a_r8_no_reload_busy: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.tick && strobe.loadCnt));

endmodule

// File: rtl/cop_control.sv
module cop_control
  import cop_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int FUNC_W = 7,
  parameter int DEST_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [FUNC_W-1:0] cmdFunc,
  input  logic [DEST_W-1:0] cmdDest,
  input  logic              addrOk,
  input  logic              cntZero,
  output ctlStrobe_t        strobe,
  output logic              rspValid,
  output logic [DEST_W-1:0] rspDest,
  output logic [XLEN-1:0]   rspData
);

  ctlState_t         stateQ, stateD;
  logic              isSet, isStart, isPoll, fire;
  logic [STAT_W-1:0] statusW;

  assign isSet   = cmdFunc < FUNC_W'(FN_START);
  assign isStart = cmdFunc == FUNC_W'(FN_START);
  assign isPoll  = cmdFunc == FUNC_W'(FN_POLL);

  always_comb begin
    if (isSet)        cmdReady = (stateQ != ST_BUSY);
    else if (isStart) cmdReady = (stateQ == ST_IDLE) || (stateQ == ST_DONE);
    else              cmdReady = 1'b1;
  end

  assign fire = cmdValid && cmdReady;

  always_comb begin
    statusW             = '0;
    statusW[ST_BIT_BSY] = (stateQ == ST_BUSY);
    statusW[ST_BIT_DON] = (stateQ == ST_DONE);
    statusW[ST_BIT_OVF] = 1'b0;
    statusW[ST_BIT_ERR] = (stateQ == ST_ERR);
  end

  always_comb begin
    stateD = stateQ;
    if (stateQ == ST_BUSY) begin
      if (cntZero) stateD = ST_DONE;
    end else if (fire && isSet) begin
      stateD = ST_IDLE;
    end else if (fire && isStart) begin
      stateD = addrOk ? ST_BUSY : ST_ERR;
    end
  end

  always_comb begin
    strobe = '0;
    for (int k = 0; k < NUM_BASE; k++) begin
      strobe.wrBase[k] = fire && (cmdFunc == FUNC_W'(k));
    end
    strobe.loadCnt = fire && isStart && addrOk;
    strobe.tick    = (stateQ == ST_BUSY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      rspValid <= 1'b0;
      rspDest  <= '0;
      rspData  <= '0;
    end else begin
      stateQ   <= stateD;
      rspValid <= fire;
      if (fire) begin
        rspDest <= cmdDest;
        rspData <= isPoll ? XLEN'(statusW) : '0;
      end
    end
  end

  // R1: every accepted command is answered on the next cycle
  a_r1_rsp_after_fire: assert property (@(posedge clk) disable iff (!rstN)
    fire |=> rspValid);

  // R1: no response without an accepted command
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !fire |=> !rspValid);

  // R10: error never leads straight to busy
  a_r10_err_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_ERR) |=> (stateQ != ST_BUSY));

  // R7: a failed address check on start lands in error
  a_r7_bad_addr_to_err: assert property (@(posedge clk) disable iff (!rstN)
    (fire && isStart && !addrOk) |=> (stateQ == ST_ERR));

  // R8: an expired countdown ends the busy phase
  a_r8_zero_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_BUSY && cntZero) |=> (stateQ == ST_DONE));

  // R2: status holds at most one of busy, done, error
  a_r2_status_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({statusW[ST_BIT_BSY], statusW[ST_BIT_DON], statusW[ST_BIT_ERR]}));

endmodule

// File: rtl/cop_cmd_ctrl.sv
module cop_cmd_ctrl
  import cop_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int FUNC_W = 7,
  parameter int DEST_W = 5,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [FUNC_W-1:0] cmdFunc,
  input  logic [XLEN-1:0]   cmdOperand,
  input  logic [DEST_W-1:0] cmdDest,
  output logic              rspValid,
  output logic [DEST_W-1:0] rspDest,
  output logic [XLEN-1:0]   rspData
);

  ctlStrobe_t strobe;
  logic       addrOk;
  logic       cntZero;

  cop_control #(
    .XLEN   (XLEN),
    .FUNC_W (FUNC_W),
    .DEST_W (DEST_W)
  ) i_control (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdReady (cmdReady),
    .cmdFunc  (cmdFunc),
    .cmdDest  (cmdDest),
    .addrOk   (addrOk),
    .cntZero  (cntZero),
    .strobe   (strobe),
    .rspValid (rspValid),
    .rspDest  (rspDest),
    .rspData  (rspData)
  );

  cop_datapath #(
    .XLEN  (XLEN),
    .CNT_W (CNT_W)
  ) i_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .operand (cmdOperand),
    .addrOk  (addrOk),
    .cntZero (cntZero)
  );

endmodule

// File: tb/test_cop_cmd_ctrl.sv
`timescale 1ns/1ps
module test_cop_cmd_ctrl;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [6:0]  cmdFunc = '0;
  logic [63:0] cmdOperand = '0;
  logic [4:0]  cmdDest = '0;
  logic        rspValid;
  logic [4:0]  rspDest;
  logic [63:0] rspData;

  int checks = 0;
  int errors = 0;
  logic [4:0] destSeq = 5'd1;

  always #4 clk = ~clk;

  cop_cmd_ctrl i_cop_cmd_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdFunc(cmdFunc), .cmdOperand(cmdOperand), .cmdDest(cmdDest),
    .rspValid(rspValid), .rspDest(rspDest), .rspData(rspData)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one command, one clock edge
  task automatic doCmd(input logic [6:0] f, input logic [63:0] op, input bit expReady,
                       input string tag, output logic [63:0] data);
    logic rdy;
    logic [4:0] d;
    d = destSeq;
    destSeq = destSeq + 5'd3;
    @(negedge clk);
    cmdValid = 1'b1; cmdFunc = f; cmdOperand = op; cmdDest = d;
    #1;
    rdy = cmdReady;
    chk(rdy == expReady, {tag, " ready"}, 64'(rdy), 64'(expReady));
    @(posedge clk);
    #1;
    chk(rspValid == rdy, "R1 rspValid", 64'(rspValid), 64'(rdy));
    if (rdy) chk(rspDest == d, "R1 rspDest", 64'(rspDest), 64'(d));
    data = rspData;
    cmdValid = 1'b0;
  endtask

  task automatic poll(input logic [63:0] exp, input string tag);
    logic [63:0] v;
    doCmd(7'd4, 64'h0, 1'b1, "R2 poll", v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic setCmd(input logic [6:0] f, input logic [63:0] a);
    logic [63:0] v;
    doCmd(f, a, 1'b1, "R3 set", v);
    chk(v == 64'h0, "R3 set ack", v, 64'h0);
  endtask

  task automatic setAll(input logic [63:0] ai, input logic [63:0] ak, input logic [63:0] ao);
    setCmd(7'd0, ai); setCmd(7'd1, ak); setCmd(7'd2, ao);
  endtask

  task automatic startCmd(input logic [63:0] n, input bit expReady);
    logic [63:0] v;
    doCmd(7'd3, n, expReady, "R5 start", v);
    if (expReady) chk(v == 64'h0, "R8 start ack", v, 64'h0);
  endtask

  // busy for N+1 polls, then done
  task automatic runCheck(input int n);
    for (int k = 1; k <= n + 1; k++) poll(64'h1, "R8 busy window");
    poll(64'h2, "R8 done after N+1");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(posedge clk);
    #1;
    chk(rspValid == 1'b0, "R12 rspValid in reset", 64'(rspValid), 64'h0);
    @(negedge clk); rstN = 1'b1;
    poll(64'h0, "R12 status after reset");

    // R7 input base low-bit sweep
    for (int lo = 0; lo < 8; lo++) begin
      setAll(64'h1000 | 64'(lo), 64'h2000, 64'h3000);
      startCmd(64'd1, 1'b1);
      if (lo != 0) poll(64'h8, "R7 input misaligned");
      else runCheck(1);
    end
    // R7 kernel base: only bit 0 matters
    for (int lo = 0; lo < 8; lo++) begin
      setAll(64'h1000, 64'h2000 | 64'(lo), 64'h3000);
      startCmd(64'd0, 1'b1);
      if (lo[0]) poll(64'h8, "R7 kernel odd");
      else runCheck(0);
    end
    // R7 output base low-bit sweep
    for (int lo = 0; lo < 8; lo++) begin
      setAll(64'h1000, 64'h2000, 64'h3000 | 64'(lo));
      startCmd(64'd0, 1'b1);
      if (lo != 0) poll(64'h8, "R7 output misaligned");
      else runCheck(0);
    end

    // R6 zero base, R10 error exit, R5 start refused in error
    for (int z = 0; z < 3; z++) begin
      setAll(z == 0 ? 64'h0 : 64'h1000, z == 1 ? 64'h0 : 64'h2002, z == 2 ? 64'h0 : 64'h3008);
      startCmd(64'd0, 1'b1);
      poll(64'h8, "R6 zero base");
      startCmd(64'd0, 1'b0);
      poll(64'h8, "R10 error held after refused start");
      doCmd(7'd5, 64'h0, 1'b1, "R11 invalid in error", v);
      poll(64'h8, "R11 error unchanged");
      setCmd(7'd1, 64'h2000);
      poll(64'h0, "R10 set clears error to idle");
    end

    // R8 countdown sweep, R9 restart from done
    setAll(64'h4000, 64'h5000, 64'h6000);
    for (int n = 0; n < 7; n++) begin
      startCmd(64'(n), 1'b1);
      runCheck(n);
      poll(64'h2, "R9 done holds");
    end
    setCmd(7'd2, 64'h6008);
    poll(64'h0, "R9 set in done returns idle");

    // R11 all unknown codes in idle
    for (int f = 5; f < 128; f++) begin
      doCmd(7'(f), 64'hFFFF, 1'b1, "R11 invalid accepted", v);
      chk(v == 64'h0, "R11 invalid ack zero", v, 64'h0);
    end
    poll(64'h0, "R11 idle unchanged");

    // R11 unknown codes during busy do not disturb the countdown
    startCmd(64'd3, 1'b1);
    doCmd(7'd5, 64'h0, 1'b1, "R11 invalid in busy", v);
    doCmd(7'd127, 64'h0, 1'b1, "R11 invalid in busy", v);
    poll(64'h1, "R11 busy continues");
    poll(64'h1, "R11 busy continues");
    poll(64'h2, "R11 countdown intact");
    doCmd(7'd9, 64'h0, 1'b1, "R11 invalid in done", v);
    poll(64'h2, "R11 done unchanged");

    // R4 set refused in busy, R5 start refused in busy
    begin
      int cnt;
      startCmd(64'd20, 1'b1);
      doCmd(7'd0, 64'h7, 1'b0, "R4 set refused busy", v);
      startCmd(64'd1, 1'b0);
      cnt = 0;
      v = 64'h1;
      while (v == 64'h1 && cnt < 40) begin
        doCmd(7'd4, 64'h0, 1'b1, "R2 poll", v);
        cnt++;
      end
      chk(v == 64'h2, "R8 long run ends in done", v, 64'h2);
      chk(cnt == 20, "R8 long run length", 64'(cnt), 64'd20);
      startCmd(64'd0, 1'b1);
      runCheck(0);  // addresses untouched by refused set (R4)
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule